// File: doc/BRIEF.md
# Memory Bandwidth Test Sequencer

This block exercises a memory controller through its native user port and measures the throughput it gets. The port has three parts: a command channel with an enable/ready pair, a write-data channel with valid, end and ready, and a read-data channel with a valid strobe. After the controller reports that calibration is done, a start pulse begins the run. The block writes `NUM_WORDS` wide words to consecutive burst addresses. Once every write has been accepted, it reads the same words back. Each word it writes carries a pattern built from the word's own index, so checking a returned word takes no storage.

Five saturating counters record the run: cycles spent writing, data beats written, cycles spent reading, data beats read, and the number of returned words that did not match. When the read phase ends, `done_o` rises and the five results stay frozen until the next start. The parameter `PIPELINED` chooses how reads are issued. With it cleared, only one read may be in flight at a time. With it set, read commands go out back to back and many reads can be outstanding. Comparing the two read-cycle counts shows what pipelining gains against a slow read return.

Top module: `mem_bw_tester`

## Requirements
- R1: After reset, `done_o`, `cmd_en_o` and `wdata_vld_o` are low. A start is taken only while idle or done, and only when `calib_done_i` and `start_i` are both high. Otherwise `start_i` has no effect.
- R2: The write phase offers exactly `NUM_WORDS` write commands (`cmd_o` = 3'b000) to addresses `index << ADDR_INC_LOG2`, with index counting up from 0. It also offers one data beat per word, each with `wdata_end_o` high.
- R3: The data for word index i has lane j (bits 32j+31..32j) equal to {j[3:0], i[27:0]}.
- R4: A command or data beat is accepted only when its valid and ready are both high. While it waits, the offer and its index stay unchanged.
- R5: Reading begins only after all write beats and commands are accepted. Read commands (`cmd_o` = 3'b001) visit the same addresses in the same order, and no write data is offered during the read phase.
- R6: With `PIPELINED`=0, at most one read is outstanding. With every ready held high and a read latency of L cycles, the read phase lasts NUM_WORDS*(L+1)+1 cycles.
- R7: With `PIPELINED`=1, a read command is offered in every read-phase cycle until all are issued. With every ready held high, the read phase lasts NUM_WORDS+L+1 cycles, and up to min(NUM_WORDS, L) reads are in flight.
- R8: The k-th returned word is compared with the pattern of index k, and each mismatch adds one to `err_cnt_o`.
- R9: `wr_cycles_o` counts the cycles from the one after the accepted start through the one in which the last write completes. `wr_words_o` counts accepted write beats. `rd_words_o` counts read beats received in the read phase.
- R10: Every result counter stops at 2^CNT_W-1 instead of wrapping.
- R11: `done_o` rises after the read phase, and the results hold until a new start. A new start clears all results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller user clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| calib_done_i | input | 1 | Controller calibration complete |
| start_i | input | 1 | Start request |
| cmd_en_o | output | 1 | Command valid |
| cmd_o | output | 3 | Command code, 000 write, 001 read |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_rdy_i | input | 1 | Controller accepts command |
| wdata_o | output | DATA_W | Write data word |
| wdata_vld_o | output | 1 | Write data valid |
| wdata_end_o | output | 1 | Last beat of the burst |
| wdata_rdy_i | input | 1 | Controller accepts write data |
| rdata_i | input | DATA_W | Read data word |
| rdata_vld_i | input | 1 | Read data valid |
| done_o | output | 1 | Run finished, results valid |
| wr_cycles_o | output | CNT_W | Write-phase cycle count |
| wr_words_o | output | CNT_W | Write beats accepted |
| rd_cycles_o | output | CNT_W | Read-phase cycle count |
| rd_words_o | output | CNT_W | Read beats received |
| err_cnt_o | output | CNT_W | Mismatching read words |

## Verification
The assertions check on every cycle that:
- a stalled command or data offer holds its index,
- the baseline build never has more than one read in flight,
- read data never arrives with no read outstanding,
- no write data is offered while reading,
- counters stay at their ceiling,
- results hold while done.

Only the bench's scenarios can show the rest: the exact phase cycle counts for a given latency, the in-flight depth reached when pipelining, the address and pattern sequence seen by the memory, and a single corrupted word being counted.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ, ST_DONE} mbt_state_e;
  localparam logic [2:0] CMD_WR = 3'b000;
  localparam logic [2:0] CMD_RD = 3'b001;
  localparam int unsigned NUM_RES = 5;
endpackage

// File: rtl/mbt_pattern.sv
module mbt_pattern #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 17
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned LANES = DATA_W / 32;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [3:0] LANE_ID = 4'(j);
    assign data_o[32*j +: 32] = {LANE_ID, 28'(idx_i)};
  end
endmodule

// File: rtl/mbt_sat_cnt.sv
module mbt_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   q_o <= '0;
    else if (clr_i)                q_o <= '0;
    else if (inc_i && q_o != MAX)  q_o <= q_o + 1'b1;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == MAX && inc_i && !clr_i) |=> q_o == MAX); // R10
endmodule

// File: rtl/mbt_wr_issue.sv
module mbt_wr_issue #(
  parameter int unsigned NUM_WORDS = 65536,
  parameter int unsigned IDX_W     = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             act_i,
  input  logic             cmd_rdy_i,
  input  logic             wd_rdy_i,
  output logic             cmd_en_o,
  output logic             wd_vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;
  logic cmd_sent_q, wd_sent_q, cmd_ok, wd_ok, word_done;

  assign cmd_en_o  = act_i & ~cmd_sent_q;
  assign wd_vld_o  = act_i & ~wd_sent_q;
  // command and data may complete in different cycles
  assign cmd_ok    = cmd_sent_q | (cmd_en_o & cmd_rdy_i);
  assign wd_ok     = wd_sent_q  | (wd_vld_o & wd_rdy_i);
  assign word_done = act_i & cmd_ok & wd_ok;
  assign last_o    = word_done & (idx_q == IDX_W'(NUM_WORDS - 1));
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; cmd_sent_q <= 1'b0; wd_sent_q <= 1'b0;
    end else if (clr_i) begin
      idx_q <= '0; cmd_sent_q <= 1'b0; wd_sent_q <= 1'b0;
    end else if (word_done) begin
      idx_q <= idx_q + 1'b1; cmd_sent_q <= 1'b0; wd_sent_q <= 1'b0;
    end else if (act_i) begin
      cmd_sent_q <= cmd_ok; wd_sent_q <= wd_ok;
    end
  end

  AST_WR_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_o && !cmd_rdy_i) |=> (cmd_en_o && $stable(idx_q))); // R4
  AST_WR_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_vld_o && !wd_rdy_i) |=> (wd_vld_o && $stable(idx_q))); // R4
endmodule

// File: rtl/mbt_rd_track.sv
module mbt_rd_track #(
  parameter int unsigned NUM_WORDS = 65536,
  parameter int unsigned IDX_W     = 17,
  parameter int unsigned DATA_W    = 128,
  parameter bit          PIPELINED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              act_i,
  input  logic              cmd_rdy_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdata_vld_i,
  output logic              cmd_en_o,
  output logic [IDX_W-1:0]  iss_idx_o,
  output logic              ret_o,
  output logic              miss_o,
  output logic              fin_o
);
  logic [IDX_W-1:0]  iss_q, ret_q, out_q;
  logic [DATA_W-1:0] exp_data;
  logic all_iss, gate, acc;

  assign all_iss = (iss_q == IDX_W'(NUM_WORDS));

  if (PIPELINED) begin : g_pipe
    assign gate = 1'b1;
  end else begin : g_single
    assign gate = (out_q == '0);
    AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_q <= IDX_W'(1)); // R6
  end

  assign cmd_en_o  = act_i & ~all_iss & gate;
  assign acc       = cmd_en_o & cmd_rdy_i;
  assign ret_o     = act_i & rdata_vld_i;
  assign fin_o     = act_i & all_iss & (out_q == '0);
  assign iss_idx_o = iss_q;

  mbt_pattern #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_exp (.idx_i(ret_q), .data_o(exp_data));

  // returns arrive in issue order, so ret_q names the expected word
  assign miss_o = ret_o & (rdata_i != exp_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_q <= '0; ret_q <= '0; out_q <= '0;
    end else if (clr_i) begin
      iss_q <= '0; ret_q <= '0; out_q <= '0;
    end else begin
      iss_q <= iss_q + IDX_W'(acc);
      ret_q <= ret_q + IDX_W'(ret_o);
      out_q <= out_q + IDX_W'(acc) - IDX_W'(ret_o);
    end
  end

  AST_RET_HAS_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o |-> out_q != '0); // R8
  AST_RD_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_o && !cmd_rdy_i) |=> (cmd_en_o && $stable(iss_q))); // R4
endmodule

// File: rtl/mem_bw_tester.sv
module mem_bw_tester
  import mbt_pkg::*;
#(
  parameter int unsigned NUM_WORDS     = 65536,
  parameter int unsigned DATA_W        = 128,
  parameter int unsigned ADDR_W        = 28,
  parameter int unsigned ADDR_INC_LOG2 = 3,
  parameter int unsigned CNT_W         = 32,
  parameter bit          PIPELINED     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calib_done_i,
  input  logic              start_i,
  output logic              cmd_en_o,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic              cmd_rdy_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wdata_vld_o,
  output logic              wdata_end_o,
  input  logic              wdata_rdy_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdata_vld_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  wr_cycles_o,
  output logic [CNT_W-1:0]  wr_words_o,
  output logic [CNT_W-1:0]  rd_cycles_o,
  output logic [CNT_W-1:0]  rd_words_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS + 1);

  mbt_state_e state_q;
  logic go, in_wr, in_rd;
  logic wr_cmd_en, wr_last, rd_cmd_en, rd_ret, rd_miss, rd_fin;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [NUM_RES-1:0] inc;
  logic [CNT_W-1:0]   res [NUM_RES];

  assign go    = (state_q == ST_IDLE || state_q == ST_DONE) && calib_done_i && start_i;
  assign in_wr = (state_q == ST_WRITE);
  assign in_rd = (state_q == ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else if (go) state_q <= ST_WRITE;
    else begin
      case (state_q)
        ST_WRITE: if (wr_last) state_q <= ST_READ;
        ST_READ:  if (rd_fin)  state_q <= ST_DONE;
        default:  state_q <= state_q;
      endcase
    end
  end

  mbt_wr_issue #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) i_wr (
    .clk_i, .rst_ni, .clr_i(go), .act_i(in_wr),
    .cmd_rdy_i, .wd_rdy_i(wdata_rdy_i),
    .cmd_en_o(wr_cmd_en), .wd_vld_o(wdata_vld_o), .idx_o(wr_idx), .last_o(wr_last)
  );

  mbt_pattern #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_wpat (.idx_i(wr_idx), .data_o(wdata_o));

  mbt_rd_track #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W),
                 .PIPELINED(PIPELINED)) i_rd (
    .clk_i, .rst_ni, .clr_i(go), .act_i(in_rd), .cmd_rdy_i,
    .rdata_i, .rdata_vld_i,
    .cmd_en_o(rd_cmd_en), .iss_idx_o(rd_idx), .ret_o(rd_ret), .miss_o(rd_miss), .fin_o(rd_fin)
  );

  assign wdata_end_o = wdata_vld_o;
  assign cmd_en_o    = wr_cmd_en | rd_cmd_en;
  assign cmd_o       = in_rd ? CMD_RD : CMD_WR;
  assign cmd_addr_o  = (in_rd ? ADDR_W'(rd_idx) : ADDR_W'(wr_idx)) << ADDR_INC_LOG2;
  assign done_o      = (state_q == ST_DONE);

  // result order: write cycles, write words, read cycles, read words, mismatches
  assign inc = {rd_miss, rd_ret, in_rd, wdata_vld_o & wdata_rdy_i, in_wr};

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    mbt_sat_cnt #(.W(CNT_W)) i_cnt (
      .clk_i, .rst_ni, .clr_i(go), .inc_i(inc[g]), .q_o(res[g])
    );
  end

  assign wr_cycles_o = res[0];
  assign wr_words_o  = res[1];
  assign rd_cycles_o = res[2];
  assign rd_words_o  = res[3];
  assign err_cnt_o   = res[4];

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_wr || in_rd) |-> (!cmd_en_o && !wdata_vld_o)); // R1
  AST_NO_WDATA_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rd |-> !wdata_vld_o); // R5
  AST_RESULTS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !go) |=> (done_o && $stable({wr_cycles_o, wr_words_o, rd_cycles_o,
                                            rd_words_o, err_cnt_o}))); // R11
endmodule

// File: tb/mem_model.sv
module mem_model #(
  parameter int N  = 8,
  parameter int DW = 128,
  parameter int AW = 28,
  parameter int SH = 3
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          cmd_en,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic          cmd_rdy,
  input  logic [DW-1:0] wd,
  input  logic          wd_vld,
  input  logic          wd_end,
  input  logic          wd_rdy,
  input  int            lat,
  input  int            corrupt,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld,
  output int            bad,
  output int            max_out
);
  logic [DW-1:0] mem [N];
  logic [DW-1:0] pd [64];
  logic          pv [64];
  int wc, wdc, rc, outs;

  function automatic logic [DW-1:0] pat(int idx);
    logic [DW-1:0] r;
    for (int j = 0; j < DW / 32; j++) r[32*j +: 32] = {4'(j), 28'(idx)};
    return r;
  endfunction

  assign rdata_vld = pv[lat-1];
  assign rdata     = pd[lat-1];

  always @(posedge clk) begin
    int b, n, racc;
    if (clr) begin
      wc <= 0; wdc <= 0; rc <= 0; outs <= 0; bad <= 0; max_out <= 0;
      for (int i = 0; i < 64; i++) pv[i] <= 1'b0;
    end else begin
      b = bad; racc = 0;
      for (int i = 63; i > 0; i--) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
      pv[0] <= 1'b0;
      if (cmd_en && cmd_rdy) begin
        if (cmd == 3'b000) begin
          if (addr != AW'(wc << SH) || rc != 0) b++;
          wc <= wc + 1;
        end else if (cmd == 3'b001) begin
          if (addr != AW'(rc << SH) || wdc != N || wc != N) b++;
          pv[0] <= 1'b1;
          pd[0] <= mem[rc % N] ^ ((rc == corrupt) ? DW'(32) : DW'(0));
          rc <= rc + 1; racc = 1;
        end else b++;
      end
      if (wd_vld && wd_rdy) begin
        if (!wd_end || wd != pat(wdc)) b++;
        mem[wdc % N] <= wd;
        wdc <= wdc + 1;
      end
      n = outs + racc - (rdata_vld ? 1 : 0);
      outs <= n;
      if (n > max_out) max_out <= n;
      bad <= b;
    end
  end
endmodule

// File: tb/test_mem_bw_tester.sv
module test_mem_bw_tester;
  localparam int N = 8, DW = 128, AW = 28, SH = 3, CW = 8;

  typedef struct packed {
    int lat; int corrupt; int exp_pip_rd; int exp_base_rd; int exp_err;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{lat: 1,  corrupt: -1, exp_pip_rd: 10, exp_base_rd: 17,  exp_err: 0},
    '{lat: 22, corrupt: -1, exp_pip_rd: 31, exp_base_rd: 185, exp_err: 0},
    '{lat: 5,  corrupt: 3,  exp_pip_rd: 14, exp_base_rd: 49,  exp_err: 1},
    '{lat: 40, corrupt: -1, exp_pip_rd: 49, exp_base_rd: 255, exp_err: 0}
  };

  logic clk = 0, rst_n = 0, calib = 0, start = 0, cmd_rdy = 1, wd_rdy = 1, mclr = 1;
  int lat = 1, corrupt = -1;
  int errors = 0, checks = 0;

  logic          p_en, p_wv, p_we, p_rv, p_done, b_en, b_wv, b_we, b_rv, b_done;
  logic [2:0]    p_cmd, b_cmd;
  logic [AW-1:0] p_addr, b_addr;
  logic [DW-1:0] p_wd, p_rd, b_wd, b_rd;
  logic [CW-1:0] p_res [5], b_res [5];
  int p_bad, p_max, b_bad, b_max;

  always #10 clk = ~clk;

  mem_bw_tester #(.NUM_WORDS(N), .DATA_W(DW), .ADDR_W(AW), .ADDR_INC_LOG2(SH),
                  .CNT_W(CW), .PIPELINED(1'b1)) i_mem_bw_tester (
    .clk_i(clk), .rst_ni(rst_n), .calib_done_i(calib), .start_i(start),
    .cmd_en_o(p_en), .cmd_o(p_cmd), .cmd_addr_o(p_addr), .cmd_rdy_i(cmd_rdy),
    .wdata_o(p_wd), .wdata_vld_o(p_wv), .wdata_end_o(p_we), .wdata_rdy_i(wd_rdy),
    .rdata_i(p_rd), .rdata_vld_i(p_rv), .done_o(p_done),
    .wr_cycles_o(p_res[0]), .wr_words_o(p_res[1]), .rd_cycles_o(p_res[2]),
    .rd_words_o(p_res[3]), .err_cnt_o(p_res[4]));

  mem_bw_tester #(.NUM_WORDS(N), .DATA_W(DW), .ADDR_W(AW), .ADDR_INC_LOG2(SH),
                  .CNT_W(CW), .PIPELINED(1'b0)) i_mem_bw_tester_base (
    .clk_i(clk), .rst_ni(rst_n), .calib_done_i(calib), .start_i(start),
    .cmd_en_o(b_en), .cmd_o(b_cmd), .cmd_addr_o(b_addr), .cmd_rdy_i(cmd_rdy),
    .wdata_o(b_wd), .wdata_vld_o(b_wv), .wdata_end_o(b_we), .wdata_rdy_i(wd_rdy),
    .rdata_i(b_rd), .rdata_vld_i(b_rv), .done_o(b_done),
    .wr_cycles_o(b_res[0]), .wr_words_o(b_res[1]), .rd_cycles_o(b_res[2]),
    .rd_words_o(b_res[3]), .err_cnt_o(b_res[4]));

  mem_model #(.N(N), .DW(DW), .AW(AW), .SH(SH)) i_mem_p (
    .clk, .clr(mclr), .cmd_en(p_en), .cmd(p_cmd), .addr(p_addr), .cmd_rdy,
    .wd(p_wd), .wd_vld(p_wv), .wd_end(p_we), .wd_rdy, .lat, .corrupt,
    .rdata(p_rd), .rdata_vld(p_rv), .bad(p_bad), .max_out(p_max));

  mem_model #(.N(N), .DW(DW), .AW(AW), .SH(SH)) i_mem_b (
    .clk, .clr(mclr), .cmd_en(b_en), .cmd(b_cmd), .addr(b_addr), .cmd_rdy,
    .wd(b_wd), .wd_vld(b_wv), .wd_end(b_we), .wd_rdy, .lat, .corrupt,
    .rdata(b_rd), .rdata_vld(b_rv), .bad(b_bad), .max_out(b_max));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_start();
    @(negedge clk); mclr = 1;
    @(negedge clk); mclr = 0; start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      if (p_done && b_done) break;
      @(negedge clk);
    end
    check("R11 done raised", int'(p_done && b_done), 1);
  endtask

  task automatic check_run(int wr_cyc, int pip_rd, int base_rd, int err);
    check("R9 pipelined write cycles", int'(p_res[0]), wr_cyc);
    check("R9 baseline write cycles", int'(b_res[0]), wr_cyc);
    check("R9 write words", int'(p_res[1]) + int'(b_res[1]), 2 * N);
    check("R7 pipelined read cycles", int'(p_res[2]), pip_rd);
    check("R6 R10 baseline read cycles", int'(b_res[2]), base_rd);
    check("R9 read words", int'(p_res[3]) + int'(b_res[3]), 2 * N);
    check("R8 pipelined mismatches", int'(p_res[4]), err);
    check("R8 baseline mismatches", int'(b_res[4]), err);
    check("R2 R3 R5 pipelined bus order", p_bad, 0);
    check("R2 R3 R5 baseline bus order", b_bad, 0);
    check("R7 pipelined in flight", p_max, (lat < N) ? lat : N);
    check("R6 baseline in flight", b_max, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 done after reset", int'(p_done || b_done), 0);
    check("R1 cmd_en after reset", int'(p_en || b_en), 0);
    check("R1 wdata_vld after reset", int'(p_wv || b_wv), 0);
    // R1 start without calibration is ignored
    run_start();
    repeat (10) @(negedge clk);
    check("R1 start without calib", int'(p_en || b_en || p_wv || p_done || b_done), 0);
    calib = 1;

    foreach (VECS[v]) begin
      lat = VECS[v].lat; corrupt = VECS[v].corrupt;
      run_start();
      wait_done();
      check_run(N, VECS[v].exp_pip_rd, VECS[v].exp_base_rd, VECS[v].exp_err);
    end

    // R11 results hold while done and calib low start is ignored
    calib = 0;
    start = 1;
    repeat (20) @(negedge clk);
    start = 0;
    check("R11 results held", int'(p_res[2]), VECS[3].exp_pip_rd);
    check("R1 R11 done held", int'(p_done && b_done), 1);
    calib = 1;

    // R4 stalled write handshake
    lat = 3; corrupt = -1;
    cmd_rdy = 0; wd_rdy = 0;
    run_start();
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R4 command held while stalled", int'(p_en && b_en && p_addr == '0 && b_addr == '0), 1);
    check("R4 data held while stalled", int'(p_wv && b_wv), 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    cmd_rdy = 1; wd_rdy = 1;
    wait_done();
    check_run(N + 20, N + 3 + 1, N * 4 + 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule